// File: doc/BRIEF.md
# Transmit/Receive FIFO Pair with Status Word and Level Requests

This block sits between a serial shift engine and the bus side of a serial-peripheral controller. It holds two word queues. The transmit queue is filled from the bus side and drained by the engine. The receive queue is filled by the engine and drained from the bus side.

One 32-bit status word reports the following:
- empty and full flags for each queue;
- the number of free transmit slots;
- the number of filled receive entries;
- sticky error flags for queue misuse, plus a summary error bit.

The same word accepts writes. A 1 written to an error bit clears that bit, and a 1 written to a flush bit empties the matching queue.

Each direction also has a request output for a DMA engine and an interrupt output. Each of these asserts while its queue has crossed a selectable level of 1, 4, 8 or 16 entries.

Top module: `xfer_fifo_pair`

## Requirements
- R1: Each queue holds up to 64 words of 32 bits and returns them in the order written. The read data port shows the oldest word without consuming it, and a read strobe consumes it.
- R2: Status word bits are: 0 receive empty, 1 receive full, 2 transmit empty, 3 transmit full. Bits 22:16 hold the free transmit slots and bits 29:23 hold the filled receive entries, as 7-bit values. After reset the word reads 0x0040_0005.
- R3: A write into a full queue is dropped and leaves the contents unchanged. It sets a sticky overflow flag on the next edge: bit 7 for transmit, bit 5 for receive.
- R4: A read from an empty queue returns zero and moves no pointer. It sets a sticky underflow flag: bit 6 for transmit, bit 4 for receive.
- R5: Any overflow or underflow event also sets the sticky summary error bit 8.
- R6: A status write with a 1 in any of bits 8:4 clears that flag, and a 0 leaves it alone. An event in the same cycle as a clear keeps the flag set.
- R7: A status write with bit 14 set empties the transmit queue in one cycle, and bit 15 does the same for the receive queue. The sticky flags are unchanged. A write or read to that queue in the flush cycle is ignored and raises no flag.
- R8: A 2-bit level code selects a level: 0 means 1 entry, 1 means 4, 2 means 8, 3 means 16. The transmit condition holds while free slots are at or above the transmit level. The receive condition holds while filled entries are at or above the receive level.
- R9: Each DMA request equals its condition ANDed with the DMA enable. Each interrupt equals its condition ANDed with that direction's interrupt enable.
- R10: A write and a read to the same queue in one cycle, neither empty nor full, leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_wr_en | input | 1 | Write strobe into the transmit queue |
| tx_wr_data | input | 32 | Transmit write word |
| tx_rd_en | input | 1 | Engine read strobe from the transmit queue |
| tx_rd_data | output | 32 | Oldest transmit word, zero when empty |
| rx_wr_en | input | 1 | Engine write strobe into the receive queue |
| rx_wr_data | input | 32 | Receive write word |
| rx_rd_en | input | 1 | Read strobe from the receive queue |
| rx_rd_data | output | 32 | Oldest receive word, zero when empty |
| stat_wr_en | input | 1 | Status write strobe (clear and flush) |
| stat_wr_data | input | 32 | Status write value |
| stat_rd_data | output | 32 | Status word |
| cfg_tx_lvl | input | 2 | Transmit level code |
| cfg_rx_lvl | input | 2 | Receive level code |
| cfg_dma_en | input | 1 | DMA request enable |
| cfg_tx_ie | input | 1 | Transmit interrupt enable |
| cfg_rx_ie | input | 1 | Receive interrupt enable |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The assertions check the following on every cycle:
- occupancy never exceeds the depth;
- a flush always leaves a queue empty;
- misuse of a full or empty queue never moves it;
- a sticky flag holds until cleared and drops after a clear with no event;
- any error event raises the summary bit;
- a level request never asserts while its queue has nothing to offer.

Other behaviours can only be shown by the bench's scenarios. These are FIFO ordering across a full queue, a dropped overflow word never appearing at the read port, zero read data on underflow, the exact level thresholds for each code, and event-over-clear priority.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;

    localparam int unsigned STAT_W     = 32;
    localparam int unsigned STAT_CNT_W = 7;

    // status word bit positions
    localparam int unsigned SB_RX_EMPTY = 0;
    localparam int unsigned SB_RX_FULL  = 1;
    localparam int unsigned SB_TX_EMPTY = 2;
    localparam int unsigned SB_TX_FULL  = 3;
    localparam int unsigned SB_TX_FLUSH = 14;
    localparam int unsigned SB_RX_FLUSH = 15;
    localparam int unsigned SB_TX_FREE  = 16;
    localparam int unsigned SB_RX_FILL  = 23;

    // sticky flag indices; status bit = SK_BASE + index
    localparam int unsigned SK_RX_UNF = 0;
    localparam int unsigned SK_RX_OVF = 1;
    localparam int unsigned SK_TX_UNF = 2;
    localparam int unsigned SK_TX_OVF = 3;
    localparam int unsigned SK_ERR    = 4;
    localparam int unsigned SK_N      = 5;
    localparam int unsigned SK_BASE   = 4;

    typedef enum logic [1:0] {
        LVL_1  = 2'd0,
        LVL_4  = 2'd1,
        LVL_8  = 2'd2,
        LVL_16 = 2'd3
    } lvl_code_e;

    typedef struct packed {
        logic empty;
        logic full;
        logic ovf_evt;
        logic unf_evt;
    } fifo_flags_t;

    function automatic int unsigned lvl_entries(lvl_code_e code);
        case (code)
            LVL_1:   return 1;
            LVL_4:   return 4;
            LVL_8:   return 8;
            default: return 16;
        endcase
    endfunction

endpackage

// File: rtl/xfer_fifo.sv
module xfer_fifo
    import fifo_pair_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned WIDTH = 32,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic [CNT_W-1:0] count,
    output fifo_flags_t      flags
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             is_empty;
    logic             is_full;
    logic             do_push;
    logic             do_pop;

    function automatic logic [AW-1:0] ptr_inc(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign is_empty = (count == '0);
    assign is_full  = (count == CNT_W'(DEPTH));
    assign do_push  = push && !is_full && !flush;
    assign do_pop   = pop && !is_empty && !flush;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    assign pop_data      = is_empty ? '0 : mem[rd_ptr];
    assign flags.empty   = is_empty;
    assign flags.full    = is_full;
    assign flags.ovf_evt = push && is_full && !flush;
    assign flags.unf_evt = pop && is_empty && !flush;

    // R1
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0));

    // R3
    ovf_no_move_chk: assert property (@(posedge clk) disable iff (rst)
        (push && is_full && !pop && !flush) |=> (count == CNT_W'(DEPTH)));

    // R4
    unf_no_move_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && is_empty && !push && !flush) |=> (count == '0));

endmodule

// File: rtl/lvl_trigger.sv
module lvl_trigger
    import fifo_pair_pkg::*;
#(
    parameter int unsigned CNT_W = 7
) (
    input  logic [CNT_W-1:0] level_cnt,
    input  lvl_code_e        code,
    input  logic             dma_en,
    input  logic             irq_en,
    output logic             dma_req,
    output logic             irq_req
);

    logic [CNT_W-1:0] threshold;
    logic             hit;

    assign threshold = CNT_W'(lvl_entries(code));
    assign hit       = (level_cnt >= threshold);
    assign dma_req   = hit && dma_en;
    assign irq_req   = hit && irq_en;

endmodule

// File: rtl/fifo_status.sv
module fifo_status
    import fifo_pair_pkg::*;
#(
    parameter int unsigned CNT_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    input  fifo_flags_t       tx_flags,
    input  fifo_flags_t       rx_flags,
    input  logic [CNT_W-1:0]  tx_free,
    input  logic [CNT_W-1:0]  rx_fill,
    output logic [STAT_W-1:0] status,
    output logic              tx_flush,
    output logic              rx_flush
);

    logic [SK_N-1:0] evt;
    logic [SK_N-1:0] clr;
    logic [SK_N-1:0] sticky;
    logic            unused_wr_bits;

    assign evt[SK_RX_UNF] = rx_flags.unf_evt;
    assign evt[SK_RX_OVF] = rx_flags.ovf_evt;
    assign evt[SK_TX_UNF] = tx_flags.unf_evt;
    assign evt[SK_TX_OVF] = tx_flags.ovf_evt;
    assign evt[SK_ERR]    = rx_flags.unf_evt | rx_flags.ovf_evt |
                            tx_flags.unf_evt | tx_flags.ovf_evt;

    assign clr      = wr_en ? wr_data[SK_BASE +: SK_N] : '0;
    assign tx_flush = wr_en && wr_data[SB_TX_FLUSH];
    assign rx_flush = wr_en && wr_data[SB_RX_FLUSH];
    assign unused_wr_bits = ^{wr_data[STAT_W-1:SB_RX_FLUSH+1],
                              wr_data[SB_TX_FLUSH-1:SK_BASE+SK_N],
                              wr_data[SK_BASE-1:0]};

    for (genvar i = 0; i < SK_N; i++) begin : g_sticky
        always_ff @(posedge clk) begin
            if (rst) sticky[i] <= 1'b0;
            else     sticky[i] <= (sticky[i] && !clr[i]) || evt[i];
        end

        // R6
        sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (sticky[i] && !clr[i]) |=> sticky[i]);

        // R6
        w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !evt[i]) |=> !sticky[i]);
    end

    // R5
    err_summary_chk: assert property (@(posedge clk) disable iff (rst)
        (|evt[SK_TX_OVF:SK_RX_UNF]) |=> sticky[SK_ERR]);

    always_comb begin
        status = '0;
        status[SB_RX_EMPTY] = rx_flags.empty;
        status[SB_RX_FULL]  = rx_flags.full;
        status[SB_TX_EMPTY] = tx_flags.empty;
        status[SB_TX_FULL]  = tx_flags.full;
        status[SK_BASE +: SK_N] = sticky;
        status[SB_TX_FREE +: STAT_CNT_W] = STAT_CNT_W'(tx_free);
        status[SB_RX_FILL +: STAT_CNT_W] = STAT_CNT_W'(rx_fill);
    end

endmodule

// File: rtl/xfer_fifo_pair.sv
module xfer_fifo_pair
    import fifo_pair_pkg::*;
#(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_wr_en,
    input  logic [DATA_W-1:0] tx_wr_data,
    input  logic              tx_rd_en,
    output logic [DATA_W-1:0] tx_rd_data,
    input  logic              rx_wr_en,
    input  logic [DATA_W-1:0] rx_wr_data,
    input  logic              rx_rd_en,
    output logic [DATA_W-1:0] rx_rd_data,
    input  logic              stat_wr_en,
    input  logic [31:0]       stat_wr_data,
    output logic [31:0]       stat_rd_data,
    input  logic [1:0]        cfg_tx_lvl,
    input  logic [1:0]        cfg_rx_lvl,
    input  logic              cfg_dma_en,
    input  logic              cfg_tx_ie,
    input  logic              cfg_rx_ie,
    output logic              tx_dma_req,
    output logic              rx_dma_req,
    output logic              tx_irq,
    output logic              rx_irq
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    fifo_flags_t      tx_flags;
    fifo_flags_t      rx_flags;
    logic [CNT_W-1:0] tx_count;
    logic [CNT_W-1:0] rx_count;
    logic [CNT_W-1:0] tx_free;
    logic             tx_flush;
    logic             rx_flush;

    assign tx_free = CNT_W'(DEPTH) - tx_count;

    xfer_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_tx_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (tx_flush),
        .push      (tx_wr_en),
        .push_data (tx_wr_data),
        .pop       (tx_rd_en),
        .pop_data  (tx_rd_data),
        .count     (tx_count),
        .flags     (tx_flags)
    );

    xfer_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_rx_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (rx_flush),
        .push      (rx_wr_en),
        .push_data (rx_wr_data),
        .pop       (rx_rd_en),
        .pop_data  (rx_rd_data),
        .count     (rx_count),
        .flags     (rx_flags)
    );

    fifo_status #(.CNT_W(CNT_W)) u_status (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (stat_wr_en),
        .wr_data  (stat_wr_data),
        .tx_flags (tx_flags),
        .rx_flags (rx_flags),
        .tx_free  (tx_free),
        .rx_fill  (rx_count),
        .status   (stat_rd_data),
        .tx_flush (tx_flush),
        .rx_flush (rx_flush)
    );

    lvl_trigger #(.CNT_W(CNT_W)) u_tx_trig (
        .level_cnt (tx_free),
        .code      (lvl_code_e'(cfg_tx_lvl)),
        .dma_en    (cfg_dma_en),
        .irq_en    (cfg_tx_ie),
        .dma_req   (tx_dma_req),
        .irq_req   (tx_irq)
    );

    lvl_trigger #(.CNT_W(CNT_W)) u_rx_trig (
        .level_cnt (rx_count),
        .code      (lvl_code_e'(cfg_rx_lvl)),
        .dma_en    (cfg_dma_en),
        .irq_en    (cfg_rx_ie),
        .dma_req   (rx_dma_req),
        .irq_req   (rx_irq)
    );

    // R8
    tx_req_room_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_dma_req || tx_irq) |-> !tx_flags.full);

    // R8
    rx_req_data_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_dma_req || rx_irq) |-> !rx_flags.empty);

endmodule

// File: tb/xfer_fifo_pair_bench.sv
`timescale 1ns/1ps
module xfer_fifo_pair_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_wr_en = 1'b0, tx_rd_en = 1'b0, rx_wr_en = 1'b0, rx_rd_en = 1'b0;
    logic [31:0] tx_wr_data = '0, rx_wr_data = '0, stat_wr_data = '0;
    logic        stat_wr_en = 1'b0;
    logic [31:0] tx_rd_data, rx_rd_data, stat_rd_data;
    logic [1:0]  cfg_tx_lvl = 2'd0, cfg_rx_lvl = 2'd0;
    logic        cfg_dma_en = 1'b0, cfg_tx_ie = 1'b0, cfg_rx_ie = 1'b0;
    logic        tx_dma_req, rx_dma_req, tx_irq, rx_irq;

    int n_chk  = 0;
    int n_fail = 0;
    int rx_wr_idx = 0;
    int rx_cnt = 0;

    always #2 clk = ~clk;

    xfer_fifo_pair u_xfer_fifo_pair (
        .clk, .rst,
        .tx_wr_en, .tx_wr_data, .tx_rd_en, .tx_rd_data,
        .rx_wr_en, .rx_wr_data, .rx_rd_en, .rx_rd_data,
        .stat_wr_en, .stat_wr_data, .stat_rd_data,
        .cfg_tx_lvl, .cfg_rx_lvl, .cfg_dma_en, .cfg_tx_ie, .cfg_rx_ie,
        .tx_dma_req, .rx_dma_req, .tx_irq, .rx_irq
    );

    // vector: {receive fill target[6:0], level code[1:0], expected request}
    localparam logic [9:0] LVL_VEC [12] = '{
        {7'd0,  2'd0, 1'b0}, {7'd1,  2'd0, 1'b1}, {7'd1,  2'd1, 1'b0},
        {7'd3,  2'd1, 1'b0}, {7'd4,  2'd1, 1'b1}, {7'd4,  2'd2, 1'b0},
        {7'd7,  2'd2, 1'b0}, {7'd8,  2'd2, 1'b1}, {7'd8,  2'd3, 1'b0},
        {7'd15, 2'd3, 1'b0}, {7'd16, 2'd3, 1'b1}, {7'd16, 2'd0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        tx_wr_en = 1'b0; tx_rd_en = 1'b0; rx_wr_en = 1'b0; rx_rd_en = 1'b0;
        stat_wr_en = 1'b0; stat_wr_data = '0;
    endtask

    task automatic push_rx();
        rx_wr_en = 1'b1;
        rx_wr_data = 32'h1000 + rx_wr_idx;
        rx_wr_idx++;
        rx_cnt++;
        tick();
    endtask

    task automatic push_tx(input logic [31:0] d);
        tx_wr_en = 1'b1;
        tx_wr_data = d;
        tick();
    endtask

    task automatic stat_write(input logic [31:0] v);
        stat_wr_en = 1'b1;
        stat_wr_data = v;
        tick();
    endtask

    function automatic logic [31:0] tx_free_f();
        return {25'd0, stat_rd_data[22:16]};
    endfunction
    function automatic logic [31:0] rx_fill_f();
        return {25'd0, stat_rd_data[29:23]};
    endfunction
    function automatic logic [31:0] sticky_f();
        return {27'd0, stat_rd_data[8:4]};
    endfunction

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int bad;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R2 reset state
        chk("R2 reset status", stat_rd_data, 32'h0040_0005);
        chk("R4 empty read data zero", rx_rd_data, 32'h0);
        chk("R9 requests off with enables low", {28'd0, tx_dma_req, rx_dma_req, tx_irq, rx_irq}, 32'h0);

        cfg_dma_en = 1'b1; cfg_tx_ie = 1'b1; cfg_rx_ie = 1'b1;
        #1;
        chk("R9 tx request at reset", {30'd0, tx_dma_req, tx_irq}, 32'h3);

        // R8 R9 receive level table
        for (int i = 0; i < 12; i++) begin
            while (rx_cnt < int'(LVL_VEC[i][9:3])) push_rx();
            cfg_rx_lvl = LVL_VEC[i][2:1];
            #1;
            chk("R8 rx fill count", rx_fill_f(), {25'd0, LVL_VEC[i][9:3]});
            chk("R8 rx level request", {30'd0, rx_dma_req, rx_irq},
                LVL_VEC[i][0] ? 32'h3 : 32'h0);
        end

        // R3 receive overflow
        while (rx_cnt < 64) push_rx();
        chk("R2 rx full flag and count", {stat_rd_data[1:0], 23'd0, stat_rd_data[29:23]}, {2'b10, 23'd0, 7'd64});
        rx_wr_en = 1'b1; rx_wr_data = 32'hDEAD_BEEF;
        tick();
        chk("R3 rx overflow flag", sticky_f(), 32'b10010);
        chk("R3 rx count after drop", rx_fill_f(), 32'd64);

        // R1 drain in order
        bad = 0;
        for (int k = 0; k < 64; k++) begin
            if (rx_rd_data !== 32'h1000 + k) bad++;
            rx_rd_en = 1'b1;
            tick();
        end
        rx_cnt = 0;
        chk("R1 rx order over full queue", bad, 0);

        // R4 receive underflow
        chk("R4 rx empty read zero", rx_rd_data, 32'h0);
        rx_rd_en = 1'b1;
        tick();
        chk("R4 rx underflow flag", sticky_f(), 32'b10011);
        chk("R4 rx still empty", {31'd0, stat_rd_data[0]}, 32'h1);

        // R6 write-one-to-clear
        stat_write(32'h10);
        chk("R6 clear rx underflow only", sticky_f(), 32'b10010);
        stat_write(32'h0);
        chk("R6 zero write leaves flags", sticky_f(), 32'b10010);
        rx_rd_en = 1'b1; stat_wr_en = 1'b1; stat_wr_data = 32'h10;
        tick();
        chk("R6 event beats clear", sticky_f(), 32'b10011);
        stat_write(32'h1F0);
        chk("R6 clear all flags", sticky_f(), 32'h0);

        // R1 R10 transmit path
        push_tx(32'hA0); push_tx(32'hA1); push_tx(32'hA2);
        chk("R1 tx free after three", tx_free_f(), 32'd61);
        chk("R2 tx not empty", {31'd0, stat_rd_data[2]}, 32'h0);
        chk("R1 tx head", tx_rd_data, 32'hA0);
        tx_wr_en = 1'b1; tx_wr_data = 32'hA3; tx_rd_en = 1'b1;
        tick();
        chk("R10 push and pop keep count", tx_free_f(), 32'd61);
        bad = 0;
        for (int k = 1; k < 4; k++) begin
            if (tx_rd_data !== 32'hA0 + k) bad++;
            tx_rd_en = 1'b1;
            tick();
        end
        chk("R1 tx order", bad, 0);

        // R8 R9 transmit levels
        cfg_tx_lvl = 2'd3;
        #1;
        chk("R8 tx level 16 with 64 free", {31'd0, tx_dma_req}, 32'h1);
        for (int k = 0; k < 49; k++) push_tx(32'hB000 + k);
        chk("R8 tx level 16 with 15 free", {30'd0, tx_dma_req, tx_irq}, 32'h0);
        cfg_tx_lvl = 2'd2;
        #1;
        chk("R8 tx level 8 with 15 free", {30'd0, tx_dma_req, tx_irq}, 32'h3);
        cfg_dma_en = 1'b0;
        #1;
        chk("R9 dma gated, irq kept", {30'd0, tx_dma_req, tx_irq}, 32'h1);
        cfg_dma_en = 1'b1;

        // R7 flush keeps sticky flags, ignores concurrent push
        rx_rd_en = 1'b1;
        tick();
        tx_wr_en = 1'b1; tx_wr_data = 32'hCC; stat_wr_en = 1'b1; stat_wr_data = 32'h4000;
        tick();
        chk("R7 tx flushed", {tx_free_f()[7:0], 23'd0, stat_rd_data[2]}, {8'd64, 23'd0, 1'b1});
        chk("R7 flags kept over tx flush", sticky_f(), 32'b10001);
        push_rx(); push_rx();
        rx_rd_en = 1'b1; stat_wr_en = 1'b1; stat_wr_data = 32'h8000;
        tick();
        rx_cnt = 0;
        chk("R7 rx flushed", {rx_fill_f()[7:0], 23'd0, stat_rd_data[0]}, {8'd0, 23'd0, 1'b1});
        chk("R7 no flag from flush cycle read", sticky_f(), 32'b10001);
        stat_write(32'h1F0);

        // R3 R4 transmit errors
        for (int k = 0; k < 64; k++) push_tx(32'hE000 + k);
        chk("R2 tx full flag", {31'd0, stat_rd_data[3]}, 32'h1);
        push_tx(32'hFFFF);
        chk("R3 tx overflow flag", sticky_f(), 32'b11000);
        chk("R3 tx head unchanged", tx_rd_data, 32'hE000);
        stat_write(32'h4000);
        chk("R4 tx empty read zero", tx_rd_data, 32'h0);
        tx_rd_en = 1'b1;
        tick();
        chk("R4 tx underflow flag", sticky_f(), 32'b11100);
        stat_write(32'h100);
        chk("R5 summary cleared alone", sticky_f(), 32'b01100);
        rx_rd_en = 1'b1;
        tick();
        chk("R5 summary set by event", sticky_f(), 32'b11101);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule